// File: doc/BRIEF.md
# Framed Serial Channel with Byte Queue

This block moves bytes between an on-chip queue and a single-wire asynchronous serial line. Software-side logic fills or drains an eight-entry byte queue through push and pop strobes, writes a transfer length and a direction, and pulses `start`. The channel then sends or receives that many bytes, from one to eight, with no further attention. It raises `done` when the last byte has gone out or come in.

Each character on the line begins with a low start bit. Eight data bits follow, least significant first, and then one high stop bit. Every bit lasts `bit_period` system clocks, a runtime value. A 104 µs bit at a 16 MHz clock needs 1664. The receiver synchronises the line with two flops. It takes a falling edge as a candidate start and keeps it only if the line is still low half a bit later. It then samples every following bit at its centre, so the sender's data must be steady for a margin on both sides of that point. A received byte with a low stop bit is still queued, and the framing flag is set.

Top module: `fifo_serial_chan`

## Requirements
- R1: After reset `ser_out` is 1, the queue is empty (`fifo_empty`=1, `fifo_count`=0), and `busy`, `done`, `frame_err` and `overflow` are 0.
- R2: The queue returns bytes in the order they were accepted and holds up to DEPTH (8) of them. `fifo_count` gives the occupancy, and `fifo_full` and `fifo_empty` are never both 1.
- R3: A user push while idle is accepted unless the queue is full and no pop happens in the same cycle. A refused push leaves the contents unchanged and sets `overflow`. A pop of an empty queue changes nothing.
- R4: In transmit mode (`mode_rx`=0 at `start`), each byte goes out as a start bit at 0 for exactly `bit_period` clocks, then data bits 0 to 7 of `bit_period` clocks each, then a stop bit at 1.
- R5: One transfer moves `xfer_len`+1 bytes (field value 0 to 7 means 1 to 8 bytes). When the last byte is finished, `busy` falls and `done` rises one cycle later. Bytes that were not requested stay in the queue.
- R6: In receive mode (`mode_rx`=1), bits are sampled at mid-period. A low pulse shorter than half a bit period is discarded, and the receiver resumes hunting without queueing anything.
- R7: A received byte whose stop bit samples as 0 is still queued, and `frame_err` is set.
- R8: During a receive, a user pop is honoured. If a received byte is written in the same cycle as a pop while the queue is full, both take effect, the count stays 8, and no overflow is flagged.
- R9: An accepted `start` (while `busy`=0) clears `done`, `frame_err` and `overflow` in the same edge. Clearing wins over any set in that cycle.
- R10: `ser_out` is 1 whenever the channel is not busy and throughout a receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a transfer; ignored while busy |
| mode_rx | input | 1 | Direction sampled at start: 0 transmit, 1 receive |
| xfer_len | input | CNT_W | Bytes to move minus one |
| bit_period | input | PER_W | Clocks per bit (at least 4) |
| push_valid | input | 1 | User write strobe into the queue (honoured while idle) |
| push_data | input | DATA_W | Byte to write |
| pop_ready | input | 1 | User read strobe (honoured unless transmitting) |
| pop_data | output | DATA_W | Byte at the head of the queue |
| fifo_count | output | CNT_W+1 | Queue occupancy |
| fifo_full | output | 1 | Queue holds DEPTH bytes |
| fifo_empty | output | 1 | Queue holds no byte |
| ser_in | input | 1 | Serial receive line, idle high |
| ser_out | output | 1 | Serial transmit line, idle high |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last transfer completed (sticky until next start) |
| frame_err | output | 1 | A received stop bit was low (sticky) |
| overflow | output | 1 | A write to a full queue was refused (sticky) |

## Verification
The receiver's write into the queue and a user pop can land on the same clock edge. The interesting case is when the queue already holds eight bytes. The bench first runs a one-byte receive into an empty queue and measures how many clocks pass between the start-bit edge and the occupancy change. It then preloads eight bytes, repeats the same frame, and raises `pop_ready` for exactly the cycle that ends on that measured edge. It judges the outcome by `overflow` staying low, the count remaining eight, and the drained order being the seven surviving preloads followed by the received byte.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SEND} tx_state_t;
  typedef enum logic [2:0] {RX_IDLE, RX_HUNT, RX_CHECK, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/sfc_fifo.sv
module sfc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [W-1:0]      wr_data,
  input  logic              rd_en,
  output logic [W-1:0]      rd_data,
  output logic [$clog2(DEPTH):0] count,
  output logic              full,
  output logic              empty,
  output logic              drop
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   ONE_C = 1;
  localparam logic [AW-1:0] ONE_P = 1;

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          rd_ok, wr_ok;

  assign empty   = (count == '0);
  assign full    = (count == (AW+1)'(DEPTH));
  assign rd_ok   = rd_en && !empty;
  assign wr_ok   = wr_en && (!full || rd_ok);
  assign drop    = wr_en && !wr_ok;
  assign rd_data = store[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) store[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= wp + ONE_P;
      if (rd_ok) rp <= rp + ONE_P;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + ONE_C;
        2'b01:   count <= count - ONE_C;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sfc_tx.sv
module sfc_tx
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CNT_W-1:0]  len,
  input  logic [PER_W-1:0]  period,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_data,
  output logic              q_pop,
  output logic              busy,
  output logic              fin,
  output logic              txd
);
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [BW-1:0]    STOP_IDX = BW'(DATA_W);
  localparam logic [BW-1:0]    ONE_B    = 1;
  localparam logic [CNT_W:0]   ONE_L    = 1;
  localparam logic [PER_W-1:0] ONE_T    = 1;

  tx_state_t          st;
  logic [CNT_W:0]     left;
  logic [PER_W-1:0]   tick;
  logic [BW-1:0]      bits;
  logic [DATA_W-1:0]  sh;

  assign busy  = (st != TX_IDLE);
  assign q_pop = (st == TX_LOAD) && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= TX_IDLE;
      txd  <= 1'b1;
      fin  <= 1'b0;
      left <= '0;
      tick <= '0;
      bits <= '0;
      sh   <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        TX_IDLE: if (go) begin
          left <= {1'b0, len} + ONE_L;
          st   <= TX_LOAD;
        end
        TX_LOAD: if (!q_empty) begin
          sh   <= q_data;
          txd  <= 1'b0;
          tick <= period - ONE_T;
          bits <= '0;
          st   <= TX_SEND;
        end
        TX_SEND: begin
          if (tick != '0) begin
            tick <= tick - ONE_T;
          end else begin
            tick <= period - ONE_T;
            if (bits < STOP_IDX) begin
              txd  <= sh[0];
              sh   <= {1'b0, sh[DATA_W-1:1]};
              bits <= bits + ONE_B;
            end else if (bits == STOP_IDX) begin
              txd  <= 1'b1;
              bits <= bits + ONE_B;
            end else if (left == ONE_L) begin
              fin <= 1'b1;
              st  <= TX_IDLE;
            end else begin
              left <= left - ONE_L;
              st   <= TX_LOAD;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfc_rx.sv
module sfc_rx
  import sfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [CNT_W-1:0]  len,
  input  logic [PER_W-1:0]  period,
  input  logic              rxd,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              busy,
  output logic              fin,
  output logic              ferr
);
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [BW-1:0]    LAST_D = BW'(DATA_W - 1);
  localparam logic [BW-1:0]    ONE_B  = 1;
  localparam logic [CNT_W:0]   ONE_L  = 1;
  localparam logic [PER_W-1:0] ONE_T  = 1;

  rx_state_t          st;
  logic               s1, s2;
  logic [CNT_W:0]     left;
  logic [PER_W-1:0]   tick;
  logic [BW-1:0]      bits;
  logic [DATA_W-1:0]  sh;

  assign busy = (st != RX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      s1        <= 1'b1;
      s2        <= 1'b1;
      push      <= 1'b0;
      push_data <= '0;
      fin       <= 1'b0;
      ferr      <= 1'b0;
      left      <= '0;
      tick      <= '0;
      bits      <= '0;
      sh        <= '0;
    end else begin
      s1   <= rxd;
      s2   <= s1;
      push <= 1'b0;
      fin  <= 1'b0;
      ferr <= 1'b0;
      case (st)
        RX_IDLE: if (go) begin
          left <= {1'b0, len} + ONE_L;
          st   <= RX_HUNT;
        end
        RX_HUNT: if (!s2) begin
          tick <= (period >> 1) - ONE_T;
          st   <= RX_CHECK;
        end
        RX_CHECK: begin
          if (tick != '0) begin
            tick <= tick - ONE_T;
          end else if (!s2) begin
            tick <= period - ONE_T;
            bits <= '0;
            st   <= RX_DATA;
          end else begin
            st <= RX_HUNT;
          end
        end
        RX_DATA: begin
          if (tick != '0) begin
            tick <= tick - ONE_T;
          end else begin
            sh   <= {s2, sh[DATA_W-1:1]};
            tick <= period - ONE_T;
            bits <= bits + ONE_B;
            if (bits == LAST_D) st <= RX_STOP;
          end
        end
        RX_STOP: begin
          if (tick != '0) begin
            tick <= tick - ONE_T;
          end else begin
            push      <= 1'b1;
            push_data <= sh;
            ferr      <= !s2;
            if (left == ONE_L) begin
              fin <= 1'b1;
              st  <= RX_IDLE;
            end else begin
              left <= left - ONE_L;
              st   <= RX_HUNT;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fifo_serial_chan.sv
module fifo_serial_chan #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int PER_W  = 16,
  parameter int CNT_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_rx,
  input  logic [CNT_W-1:0]  xfer_len,
  input  logic [PER_W-1:0]  bit_period,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_ready,
  output logic [DATA_W-1:0] pop_data,
  output logic [CNT_W:0]    fifo_count,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              busy,
  output logic              done,
  output logic              frame_err,
  output logic              overflow
);
  logic              tx_busy, rx_busy, tx_pop, tx_fin, rx_fin;
  logic              rx_push, rx_ferr, q_drop, q_wr, q_rd, go;
  logic [DATA_W-1:0] rx_byte, q_wdata;

  assign busy    = tx_busy || rx_busy;
  assign go      = start && !busy;
  assign q_wr    = rx_push || (push_valid && !busy);
  assign q_wdata = rx_push ? rx_byte : push_data;
  assign q_rd    = tx_pop || (pop_ready && !tx_busy);

  sfc_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(q_wr), .wr_data(q_wdata),
    .rd_en(q_rd), .rd_data(pop_data),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty),
    .drop(q_drop)
  );

  sfc_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PER_W(PER_W)) u_tx (
    .clk(clk), .rst(rst), .go(go && !mode_rx), .len(xfer_len),
    .period(bit_period), .q_empty(fifo_empty), .q_data(pop_data),
    .q_pop(tx_pop), .busy(tx_busy), .fin(tx_fin), .txd(ser_out)
  );

  sfc_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PER_W(PER_W)) u_rx (
    .clk(clk), .rst(rst), .go(go && mode_rx), .len(xfer_len),
    .period(bit_period), .rxd(ser_in), .push(rx_push),
    .push_data(rx_byte), .busy(rx_busy), .fin(rx_fin), .ferr(rx_ferr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      frame_err <= 1'b0;
      overflow  <= 1'b0;
    end else if (go) begin
      done      <= 1'b0;
      frame_err <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (tx_fin || rx_fin) done      <= 1'b1;
      if (rx_ferr)          frame_err <= 1'b1;
      if (q_drop)           overflow  <= 1'b1;
    end
  end
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH)
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic           push_valid,
  input logic           pop_ready,
  input logic           fifo_full,
  input logic           fifo_empty,
  input logic [CNT_W:0] fifo_count,
  input logic           ser_out,
  input logic           done,
  input logic           frame_err,
  input logic           overflow
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out); // R10
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= (CNT_W+1)'(DEPTH)); // R2
  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty)); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (fifo_full && push_valid && !pop_ready && !busy && !start) |=> (fifo_full && overflow)); // R3
  AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && pop_ready && !push_valid && !busy) |=> fifo_empty); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (!done && !frame_err && !overflow)); // R9
  AST_FINISH_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |=> done); // R5
endmodule

bind fifo_serial_chan sfc_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .push_valid(push_valid), .pop_ready(pop_ready),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_count(fifo_count),
  .ser_out(ser_out), .done(done), .frame_err(frame_err), .overflow(overflow)
);

// File: tb/tb_fifo_serial_chan.sv
module tb_fifo_serial_chan;
  localparam int P = 16;

  logic       clk = 0, rst = 1, start = 0, mode_rx = 0;
  logic [2:0] xfer_len = '0;
  logic [15:0] bit_period = 16'(P);
  logic       push_valid = 0, pop_ready = 0, ser_in = 1;
  logic [7:0] push_data = '0;
  logic [7:0] pop_data;
  logic [3:0] fifo_count;
  logic       fifo_full, fifo_empty, ser_out, busy, done, frame_err, overflow;

  fifo_serial_chan dut (
    .clk(clk), .rst(rst), .start(start), .mode_rx(mode_rx), .xfer_len(xfer_len),
    .bit_period(bit_period), .push_valid(push_valid), .push_data(push_data),
    .pop_ready(pop_ready), .pop_data(pop_data), .fifo_count(fifo_count),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ser_in(ser_in),
    .ser_out(ser_out), .busy(busy), .done(done), .frame_err(frame_err),
    .overflow(overflow)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, t0 = 0;
  logic [7:0] mq[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rnd8();
    return 8'($urandom);
  endfunction

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk); push_valid = 1; push_data = b;
    @(negedge clk); push_valid = 0;
    if (mq.size() < 8) mq.push_back(b);
  endtask

  task automatic pop_cmp(input string req);
    logic [7:0] e;
    @(negedge clk);
    e = (mq.size() > 0) ? mq.pop_front() : 8'h00;
    chk(pop_data == e, req, pop_data, e);
    pop_ready = 1;
    @(negedge clk); pop_ready = 0;
  endtask

  task automatic kick(input logic rx, input int n);
    @(negedge clk); start = 1; mode_rx = rx; xfer_len = 3'(n - 1);
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tx_capture(output logic [7:0] b);
    for (int i = 0; i < 20000 && ser_out; i++) @(negedge clk);
    repeat (P/2) @(negedge clk);
    chk(ser_out == 1'b0, "R4 start bit", ser_out, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (P) @(negedge clk);
      b[i] = ser_out;
    end
    repeat (P) @(negedge clk);
    chk(ser_out == 1'b1, "R4 stop bit", ser_out, 1);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stopv);
    @(negedge clk); ser_in = 0; t0 = cyc;
    repeat (P) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_in = b[i];
      repeat (P) @(negedge clk);
    end
    ser_in = stopv;
    repeat (P) @(negedge clk);
    ser_in = 1;
  endtask

  initial begin
    #(10 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b, got, pd;
    int n, extra, d;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(ser_out == 1, "R1 ser_out", ser_out, 1);
    chk(fifo_empty && fifo_count == 0, "R1 empty", fifo_count, 0);
    chk({busy, done, frame_err, overflow} == 4'b0, "R1 flags",
        {busy, done, frame_err, overflow}, 0);

    // R2 / R3 queue fill, overflow, order, empty pop
    for (int i = 0; i < 8; i++) push_byte(rnd8());
    chk(fifo_full && fifo_count == 8, "R2 full at 8", fifo_count, 8);
    @(negedge clk); push_valid = 1; push_data = 8'hEE;
    @(negedge clk); push_valid = 0;
    chk(overflow == 1, "R3 overflow set", overflow, 1);
    chk(fifo_count == 8, "R3 count kept", fifo_count, 8);
    for (int i = 0; i < 8; i++) pop_cmp("R2 order");
    @(negedge clk); pop_ready = 1;
    @(negedge clk); pop_ready = 0;
    chk(fifo_empty && fifo_count == 0, "R3 empty pop", fifo_count, 0);

    // R9 start clears flags; R4 start bit width
    push_byte(8'hA5);
    kick(0, 1);
    chk(overflow == 0 && done == 0, "R9 cleared", overflow, 0);
    for (int i = 0; i < 20000 && ser_out; i++) @(negedge clk);
    n = 0;
    while (!ser_out && n < 4*P) begin n++; @(negedge clk); end
    chk(n == P, "R4 start width", n, P);
    void'(mq.pop_front());
    wait_done();
    chk(done == 1 && busy == 0, "R5 done single", done, 1);

    // R4 / R5 random transmit rounds
    for (int r = 0; r < 3; r++) begin
      n = (r == 0) ? 8 : 1 + int'($urandom % 8);
      extra = (n == 8) ? 0 : int'($urandom % (9 - n));
      for (int i = 0; i < n + extra; i++) push_byte(rnd8());
      kick(0, n);
      for (int i = 0; i < n; i++) begin
        tx_capture(got);
        b = mq.pop_front();
        chk(got == b, "R4 tx byte", got, b);
      end
      wait_done();
      chk(done == 1 && busy == 0, "R5 done", done, 1);
      chk(fifo_count == 4'(extra), "R5 leftover", fifo_count, extra);
      for (int i = 0; i < extra; i++) pop_cmp("R2 leftover order");
    end

    // R6 / R10 random receive rounds
    for (int r = 0; r < 2; r++) begin
      n = (r == 0) ? 8 : 2 + int'($urandom % 5);
      kick(1, n);
      for (int i = 0; i < n; i++) begin
        b = rnd8();
        mq.push_back(b);
        send_frame(b, 1);
        chk(ser_out == 1, "R10 line high in rx", ser_out, 1);
      end
      wait_done();
      chk(done == 1 && frame_err == 0, "R6 rx done", done, 1);
      chk(fifo_count == 4'(n), "R6 rx count", fifo_count, n);
      for (int i = 0; i < n; i++) pop_cmp("R6 rx byte");
    end

    // R6 short glitch rejected
    kick(1, 1);
    @(negedge clk); ser_in = 0;
    repeat (3) @(negedge clk); ser_in = 1;
    repeat (2*P) @(negedge clk);
    chk(fifo_count == 0 && busy == 1, "R6 glitch ignored", fifo_count, 0);
    b = rnd8(); mq.push_back(b);
    send_frame(b, 1);
    wait_done();
    chk(fifo_count == 1, "R6 after glitch", fifo_count, 1);
    pop_cmp("R6 after glitch byte");

    // R7 framing error, byte kept
    kick(1, 1);
    b = rnd8(); mq.push_back(b);
    send_frame(b, 0);
    wait_done();
    chk(frame_err == 1, "R7 frame_err", frame_err, 1);
    chk(fifo_count == 1, "R7 byte kept", fifo_count, 1);
    pop_cmp("R7 byte value");

    // R8 calibration: edge offset of the receive write
    kick(1, 1);
    b = rnd8(); mq.push_back(b);
    fork send_frame(b, 1); join_none
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20000 && fifo_count == 0; i++) @(negedge clk);
    d = cyc - t0;
    wait_done();
    pop_cmp("R8 calib byte");
    // R8 full queue, pop in the write cycle
    for (int i = 0; i < 8; i++) push_byte(rnd8());
    kick(1, 1);
    b = rnd8();
    fork send_frame(b, 1); join_none
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20000 && cyc != t0 + d - 1; i++) @(negedge clk);
    pd = pop_data; pop_ready = 1;
    @(negedge clk); pop_ready = 0;
    got = mq.pop_front();
    mq.push_back(b);
    chk(pd == got, "R8 popped head", pd, got);
    chk(overflow == 0, "R8 no overflow", overflow, 0);
    chk(fifo_count == 8, "R8 count 8", fifo_count, 8);
    wait_done();
    for (int i = 0; i < 8; i++) pop_cmp("R8 order");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule